// File: doc/BRIEF.md
# Register-Driven SPI Master

This block is a serial peripheral interface master run by software through a byte-wide register bus with five addresses. Software chooses the idle clock level and the sampling phase, sets a 16-bit clock divisor, and places up to 32 outgoing bits in a transmit buffer one byte per write. A single write of the bit count to the control address then launches the transfer. The engine lowers the select line, produces the serial clock, shifts the outgoing bits out most significant first, and gathers the incoming bits into a receive buffer. Software reads that buffer back one byte per read.

An optional trigger output goes high for the whole of one transfer. It is armed by the same control write that launches that transfer.

The register bus has no wait states and no back-pressure. A write takes effect on the clock edge at which `wr_en` is high. Read data is combinational from `addr`. A read of the data address also consumes the byte it returns on that same edge. Control writes that arrive during a transfer are dropped, so software polls the ready bit before it launches another transfer.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset the status ready bit reads 1, `ss_n` is 1, `sck` is 0, `trig` is 0 and the divisor is 0, so a 1-bit transfer launched without a divisor write keeps `ss_n` low for 3 cycles.
- R2: Status (address 0) bit 0 reads 1 while the engine is idle and 0 for the whole time `ss_n` is low. The other status bits read 0.
- R3: A write to control (address 1) while idle starts a transfer of (bits 4:0)+1 bits: `ss_n` falls on that same clock edge. A control write during a transfer is ignored and does not change the length of that transfer.
- R4: A transfer of n bits keeps `ss_n` low for exactly (2n+1)·(D+1) clock cycles, where D is the divisor. It makes exactly 2n `sck` transitions, spaced D+1 cycles apart. There is one half-period of D+1 cycles before the first transition and one after the last.
- R5: Config (address 2) bit 0 sets the `sck` idle level. Bit 1 selects the phase. With 0, the slave's data is sampled on the leading edges and MOSI changes on the trailing edges. With 1, MOSI changes on the leading edges and data is sampled on the trailing edges. MOSI and MISO carry data most significant bit first.
- R6: The divisor (address 3) is loaded by two writes: the first sets bits 15:8 and the second sets bits 7:0.
- R7: Writes to data (address 4) fill the 32-bit transmit buffer one byte per write, starting at bits 31:24 and moving down. The fill position returns to bits 31:24 whenever a transfer starts. A transfer of n bits sends buffer bits 31 down to 32-n.
- R8: Received bits are right-aligned: the first bit received lands in bit n-1 and the last in bit 0. Each read of address 4 returns bits 7:0 of the receive buffer and then shifts the buffer down by 8.
- R9: Control bit 7 arms the trigger. `trig` is then high on exactly the cycles in which `ss_n` is low for the transfer started by that write. A transfer launched with bit 7 clear keeps `trig` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive buffer at address 4) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| sck | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| trig | output | 1 | Trigger, high during an armed transfer |

## Verification
The bench builds the block with its default 32-bit buffer width, so every length from 1 to 32 bits is swept. This covers single-bit transfers, each byte boundary, and a full-width word. Each length runs in all four polarity and phase combinations at divisors 0, 1 and 3. A behavioural slave in the bench checks the bits on both data lines, the edge count and the exact select duration computed from the length and divisor. Two further cases cover the rest: a divisor of 0x0100 confirms the order of the two divisor bytes, and a control write made mid-transfer shows that such a write is dropped.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Divisor register width (loaded as two bytes).
  localparam int unsigned DIV_W = 16;

  // Register addresses.
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_CFG  = 3'd2;
  localparam logic [2:0] A_DIV  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  // Control byte: trigger arm bit position.
  localparam int unsigned ARM_BIT = 7;

  typedef struct packed {
    logic cpha;
    logic cpol;
  } line_cfg_t;

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SIZE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic [7:0]        rx_byte,
  output line_cfg_t         cfg,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] tx_buf,
  output logic              start,
  output logic [SIZE_W-1:0] size,
  output logic              arm,
  output logic              rx_pop
);

  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic wr_ctrl, wr_cfg, wr_div, wr_data;
  logic div_lo_next_q;
  logic [PTR_W-1:0] wptr_q;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign wr_div  = wr_en && (addr == A_DIV);
  assign wr_data = wr_en && (addr == A_DATA);

  // Launch happens on the control write itself; dropped while busy.
  assign start  = wr_ctrl && !busy;
  assign size   = wdata[SIZE_W-1:0];
  assign arm    = wdata[ARM_BIT];
  assign rx_pop = rd_en && (addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_cfg) begin
      cfg <= line_cfg_t'(wdata[1:0]);
    end
  end

  // Divisor: first write high byte, second write low byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor       <= '0;
      div_lo_next_q <= 1'b0;
    end else if (wr_div) begin
      if (div_lo_next_q) begin
        divisor[7:0] <= wdata;
      end else begin
        divisor[DIV_W-1:8] <= wdata;
      end
      div_lo_next_q <= !div_lo_next_q;
    end
  end

  // Transmit fill pointer walks down from the top byte lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= PTR_W'(BYTES - 1);
    end else if (start) begin
      wptr_q <= PTR_W'(BYTES - 1);
    end else if (wr_data) begin
      wptr_q <= wptr_q - 1'b1;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (wr_data && (wptr_q == PTR_W'(g))) begin
        lane_q <= wdata;
      end
    end
    assign tx_buf[g*8 +: 8] = lane_q;
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = {7'b0, !busy};
      A_DATA:  rdata = rx_byte;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_eng_baud.sv
module spi_eng_baud
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload_q;

  assign tick = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (start) begin
      cnt_q    <= divisor;
      reload_q <= divisor;
    end else if (busy) begin
      if (cnt_q == '0) begin
        cnt_q <= reload_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SIZE_W = $clog2(DATA_W),
  localparam int unsigned EDGE_W = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size,
  input  logic              arm,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_buf,
  input  logic              tick,
  input  logic              miso,
  input  logic              rx_pop,
  output logic              busy,
  output logic              sck,
  output logic              ss_n,
  output logic              mosi,
  output logic              trig,
  output logic [7:0]        rx_byte
);

  logic              busy_q, sck_q, cpol_q, cpha_q, arm_q;
  logic [EDGE_W-1:0] edge_q, last_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic              lead, sample_now, shift_now;

  // Even edge index is a leading edge (away from idle level).
  assign lead       = !edge_q[0];
  assign sample_now = cpha_q ? !lead : lead;
  assign shift_now  = cpha_q ? (lead && (edge_q != '0)) : !lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      arm_q  <= 1'b0;
      edge_q <= '0;
      last_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sck_q  <= cpol;
      cpol_q <= cpol;
      cpha_q <= cpha;
      arm_q  <= arm;
      edge_q <= '0;
      last_q <= EDGE_W'((32'(size) + 32'd1) * 32'd2);
      sh_q   <= tx_buf;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (tick) begin
        if (edge_q == last_q) begin
          busy_q <= 1'b0;
          arm_q  <= 1'b0;
          sck_q  <= cpol_q;
        end else begin
          sck_q  <= !sck_q;
          edge_q <= edge_q + 1'b1;
          if (sample_now) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
          end
          if (shift_now) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
          end
        end
      end
    end else if (rx_pop) begin
      rx_q <= rx_q >> 8;
    end
  end

  assign busy    = busy_q;
  assign ss_n    = !busy_q;
  assign sck     = busy_q ? sck_q : cpol;
  assign mosi    = sh_q[DATA_W-1];
  assign trig    = busy_q && arm_q;
  assign rx_byte = rx_q[7:0];

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sck,
  output logic       ss_n,
  output logic       mosi,
  input  logic       miso,
  output logic       trig
);

  localparam int unsigned SIZE_W = $clog2(DATA_W);

  line_cfg_t         cfg;
  logic              cfg_cpol;
  logic [DIV_W-1:0]  divisor;
  logic [DATA_W-1:0] tx_buf;
  logic              start, arm, rx_pop, busy, tick;
  logic [SIZE_W-1:0] size;
  logic [7:0]        rx_byte;

  assign cfg_cpol = cfg.cpol;

  spi_eng_regs #(.DATA_W(DATA_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .busy    (busy),
    .rx_byte (rx_byte),
    .cfg     (cfg),
    .divisor (divisor),
    .tx_buf  (tx_buf),
    .start   (start),
    .size    (size),
    .arm     (arm),
    .rx_pop  (rx_pop)
  );

  spi_eng_baud i_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .divisor (divisor),
    .tick    (tick)
  );

  spi_eng_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .size    (size),
    .arm     (arm),
    .cpol    (cfg_cpol),
    .cpha    (cfg.cpha),
    .tx_buf  (tx_buf),
    .tick    (tick),
    .miso    (miso),
    .rx_pop  (rx_pop),
    .busy    (busy),
    .sck     (sck),
    .ss_n    (ss_n),
    .mosi    (mosi),
    .trig    (trig),
    .rx_byte (rx_byte)
  );

endmodule

// File: rtl/spi_eng_checks.sv
module spi_eng_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       sck,
  input logic       ss_n,
  input logic       trig,
  input logic       cpol
);

  // R3: select only falls on a control write.
  p_start_on_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(wr_en && (addr == 3'd1)));

  // R2: ready bit mirrors the idle state of the select line.
  p_ready_matches_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 3'd0)) |-> (rdata == {7'b0, ss_n}));

  // R5: clock rests at the configured idle level between transfers.
  p_sck_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (sck == cpol));

  // R9: trigger only inside a transfer.
  p_trig_inside_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !ss_n);

  // R9: trigger never rises in the middle of a transfer.
  p_trig_no_mid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $fell(ss_n));

  // R4: first clock transition never coincides with select falling.
  p_sck_quiet_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $stable(sck));

endmodule

bind spi_reg_engine spi_eng_checks i_checks (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .rdata (rdata),
  .sck   (sck),
  .ss_n  (ss_n),
  .trig  (trig),
  .cpol  (cfg_cpol)
);

// File: tb/test_spi_reg_engine.sv
`timescale 1ns/1ps
module test_spi_reg_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sck, ss_n, mosi, trig;
  logic       miso;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural slave state
  int          s_n = 1;
  int          s_idx = 0;
  logic [31:0] s_tx = '0;
  logic [31:0] s_rx = '0;
  bit          b_cpol = 1'b0;
  bit          b_cpha = 1'b0;
  int          edges = 0;
  int          lowc = 0;
  int          trc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = !clk;

  spi_reg_engine i_spi_reg_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .trig(trig)
  );

  initial miso = 1'b0;

  always @(negedge ss_n) begin
    s_idx = s_n - 1;
    s_rx  = '0;
    if (!b_cpha) miso = s_tx[s_idx];
  end

  always @(sck) begin
    if (rst_n && ss_n === 1'b0) begin
      edges++;
      if (sck !== b_cpol) begin
        if (!b_cpha) s_rx = {s_rx[30:0], mosi};
        else begin
          if (s_idx >= 0) miso = s_tx[s_idx];
          s_idx--;
        end
      end else begin
        if (b_cpha) s_rx = {s_rx[30:0], mosi};
        else begin
          s_idx--;
          if (s_idx >= 0) miso = s_tx[s_idx];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && ss_n === 1'b0) begin
      lowc++;
      if (trig) trc++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (ss_n === 1'b0 && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run_xfer(input bit pol, input bit pha, input logic [15:0] dv,
                          input int n, input logic [31:0] txw,
                          input logic [31:0] stx, input bit trg);
    logic [7:0]  b;
    logic [31:0] got, exp_m, exp_s;
    longint      dur;
    b_cpol = pol; b_cpha = pha;
    wr(3'd2, {6'b0, pha, pol});
    wr(3'd3, dv[15:8]);
    wr(3'd3, dv[7:0]);
    for (int i = 0; i < (n + 7) / 8; i++) wr(3'd4, txw[31 - 8*i -: 8]);
    s_n = n; s_tx = stx; edges = 0; lowc = 0; trc = 0;
    wr(3'd1, {trg, 2'b00, 5'(n - 1)});
    wait_idle();
    exp_m = txw >> (32 - n);
    exp_s = (n == 32) ? stx : (stx & ((32'd1 << n) - 32'd1));
    dur   = longint'(2*n + 1) * (longint'(dv) + 1);
    chk(s_rx == exp_m, "R7 R5 mosi bits", s_rx, exp_m);
    chk(lowc == dur, "R4 ss duration", lowc, dur);
    chk(edges == 2*n, "R4 sck edges", edges, 2*n);
    chk(sck == pol, "R5 idle level", sck, pol);
    chk(trc == (trg ? lowc : 0), "R9 trig cycles", trc, trg ? lowc : 0);
    got = '0;
    for (int i = 0; i < (n + 7) / 8; i++) begin
      rd(3'd4, b);
      got = got | (32'(b) << (8*i));
    end
    chk(got == exp_s, "R8 rx readback", got, exp_s);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, st);
    chk(st == 8'h01, "R1 status after reset", st, 8'h01);
    chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(trig == 1'b0, "R1 trig", trig, 0);

    // R1 default divisor of 0: 1-bit transfer lasts 3 cycles
    wr(3'd4, 8'h80);
    s_n = 1; s_tx = 32'h1; lowc = 0; edges = 0;
    wr(3'd1, 8'h00);
    wait_idle();
    chk(lowc == 3, "R1 default divisor", lowc, 3);
    rd(3'd4, st);
    chk(st == 8'h01, "R8 single bit", st, 8'h01);

    // R2/R3: status during transfer and ignored control write
    b_cpol = 0; b_cpha = 0;
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'hA5);
    s_n = 8; s_tx = 32'h3C; lowc = 0; trc = 0; edges = 0;
    wr(3'd1, 8'h07);
    rd(3'd0, st);
    chk(st == 8'h00, "R2 busy status", st, 8'h00);
    wr(3'd1, 8'h9F);
    wait_idle();
    chk(lowc == 17 * 2, "R3 busy write ignored", lowc, 34);
    chk(trc == 0, "R3 arm ignored while busy", trc, 0);
    chk(edges == 16, "R3 edges unchanged", edges, 16);
    rd(3'd0, st);
    chk(st == 8'h01, "R2 ready again", st, 8'h01);
    rd(3'd4, st);
    chk(st == 8'h3C, "R8 byte after busy test", st, 8'h3C);

    // R6 divisor byte order
    run_xfer(1'b0, 1'b0, 16'h0100, 1, 32'h8000_0000, 32'h0, 1'b1);

    // sweep: all modes, divisors, lengths
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 3; d++) begin
        for (int n = 1; n <= 32; n++) begin
          logic [31:0] t1, t2;
          seed = seed * 32'd1664525 + 32'd1013904223;
          t1 = seed;
          seed = seed * 32'd1664525 + 32'd1013904223;
          t2 = seed;
          run_xfer(m[0], m[1], (d == 2) ? 16'd3 : 16'(d), n, t1, t2, n[0]);
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule